// File: doc/BRIEF.md
# Direct-Map Window Address Translator

This block sits in front of a paged translation unit and decides, for every virtual address presented to it, how the address is to be mapped. An address is either passed straight through (direct mode), mapped by one of four software-programmed segment windows, rejected as non-canonical, or handed on to the paged lookup as a forward request. The decision logic is combinational; one register stage holds the result, so each request presented with `in_valid` produces its result exactly one clock later.

Each window register carries two privilege-enable bits, a virtual segment tag for 64-bit mode and a virtual/physical segment pair for 32-bit mode. Windows are searched from index 0 upward and the lowest-numbered hit decides the result. A window hit takes precedence over the canonical check, so a window may map addresses whose upper bits are not a sign extension. Only when no window hits are the upper address bits checked and the paged path requested.

Top module: `dmw_xlate`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid` and `out_fwd_req` are 0.
- R2: `out_valid` equals `in_valid` of the previous cycle; the result of a request appears one cycle after it is presented and no result appears on a cycle after an idle one.
- R3: When `in_da`=1 and `in_pg`=0 the code is MATCH (0), `out_pa` is the effective address with bits 63:48 cleared and `out_perm`=3'b111 (bit 0 read, bit 1 write, bit 2 execute), whatever the windows hold.
- R4: A window can hit only if the privilege allows it: privilege 0 (kernel) needs window bit 0 set, privilege 3 (user) needs window bit 3 set; privileges 1 and 2 never hit any window.
- R5: In 64-bit mode (`in_mode32`=0) a window's tag in bits 63:60 must equal address bits 63:60 for a hit.
- R6: In 32-bit mode the effective address is the low 32 bits of `in_va` zero-extended; a hit needs window bits 31:29 equal to address bits 31:29, and the physical address is window bits 27:25 followed by address bits 28:0, zero-extended.
- R7: When several windows hit, the lowest-numbered window supplies the result.
- R8: A 64-bit window hit gives code MATCH, `out_pa` equal to the address with bits 63:48 cleared, and `out_perm`=3'b111, even if the address is not canonical.
- R9: With no window hit, if effective address bits 63:48 are neither all zeros nor all ones, the code is BADADDR (1) and `out_fwd_req`=0.
- R10: With no window hit and a canonical address, the code is FORWARD (2), `out_fwd_req`=1 and `out_fwd_va` is the effective address.
- R11: Whenever the code is not MATCH, `out_pa` and `out_perm` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_va | input | 64 | Virtual address |
| in_da | input | 1 | Direct-address mode bit |
| in_pg | input | 1 | Paging-enable bit |
| in_priv | input | 2 | Privilege level, 0 kernel, 3 user |
| in_mode32 | input | 1 | 1 selects 32-bit addressing |
| in_win | input | 4x64 | Window registers, index 0 highest priority |
| out_valid | output | 1 | Result strobe |
| out_code | output | 2 | 0 MATCH, 1 BADADDR, 2 FORWARD |
| out_pa | output | 64 | Physical address on MATCH |
| out_perm | output | 3 | Permission vector {exec, write, read} |
| out_fwd_req | output | 1 | Paged-lookup request |
| out_fwd_va | output | 64 | Address handed to the paged lookup |

## Verification
A wrong priority pick shows up in 32-bit mode as a physical segment belonging to the wrong window, on the very result of the request that exposed it, because the two overlapping windows carry different physical segments. A wrong privilege or segment decode turns an expected MATCH into BADADDR or FORWARD, or the reverse, again on the next clock. Canonical-range errors are exposed at the edges of the 16-bit check field, and a stuck output register shows as a result strobe on an idle cycle.

// File: rtl/dmwx_pkg.sv
package dmwx_pkg;

   typedef enum logic [1:0] {
      XL_MATCH   = 2'd0,
      XL_BADADDR = 2'd1,
      XL_FORWARD = 2'd2
   } xl_code_e;

   localparam logic [2:0] PERM_NONE = 3'b000;
   localparam logic [2:0] PERM_RD   = 3'b001;
   localparam logic [2:0] PERM_WR   = 3'b010;
   localparam logic [2:0] PERM_EX   = 3'b100;
   localparam logic [2:0] PERM_ALL  = PERM_RD | PERM_WR | PERM_EX;

   localparam logic [1:0] PRIV_KERN = 2'd0;
   localparam logic [1:0] PRIV_USER = 2'd3;

endpackage

// File: rtl/dmwx_win_match.sv
module dmwx_win_match
   import dmwx_pkg::*;
#(
   parameter int ADDR_W      = 64,
   parameter int VALEN       = 48,
   parameter int SEG64_W     = 4,
   parameter int SEG32_W     = 3,
   parameter int PSEG32_LSB  = 25,
   parameter int KERN_EN_BIT = 0,
   parameter int USER_EN_BIT = 3
) (
   input  logic [ADDR_W-1:0] win,
   input  logic [ADDR_W-1:0] va,
   input  logic              mode32,
   input  logic [1:0]        priv,
   output logic              hit,
   output logic [ADDR_W-1:0] pa
);

   localparam int VSEG64_LSB = ADDR_W - SEG64_W;
   localparam int VSEG32_LSB = 32 - SEG32_W;
   localparam logic [ADDR_W-1:0] VA_MASK =
      {{(ADDR_W-VALEN){1'b0}}, {VALEN{1'b1}}};

   logic                priv_ok;
   logic                seg64_eq;
   logic                seg32_eq;
   logic [ADDR_W-1:0]   pa64;
   logic [ADDR_W-1:0]   pa32;

   always_comb begin
      priv_ok = ((priv == PRIV_KERN) && win[KERN_EN_BIT]) ||
                ((priv == PRIV_USER) && win[USER_EN_BIT]);
   end

   always_comb begin
      seg64_eq = (win[VSEG64_LSB +: SEG64_W] == va[VSEG64_LSB +: SEG64_W]);
      seg32_eq = (win[VSEG32_LSB +: SEG32_W] == va[VSEG32_LSB +: SEG32_W]);
   end

   always_comb begin
      pa64 = va & VA_MASK;
      pa32 = {{(ADDR_W-32){1'b0}},
              win[PSEG32_LSB +: SEG32_W],
              va[VSEG32_LSB-1:0]};
   end

   always_comb begin
      hit = priv_ok && (mode32 ? seg32_eq : seg64_eq);
      pa  = mode32 ? pa32 : pa64;
   end

endmodule

// File: rtl/dmwx_first_hit.sv
module dmwx_first_hit #(
   parameter int N     = 4,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     hits,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      any = |hits;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i]) begin
            idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/dmwx_canon.sv
module dmwx_canon #(
   parameter int ADDR_W  = 64,
   parameter int VALEN   = 48,
   parameter int CANON_W = 16
) (
   input  logic [ADDR_W-1:0] va,
   output logic              ok
);

   logic [CANON_W-1:0] ext;

   always_comb begin
      ext = va[VALEN +: CANON_W];
      ok  = (&ext) || (~|ext);
   end

endmodule

// File: rtl/dmw_xlate.sv
module dmw_xlate
   import dmwx_pkg::*;
#(
   parameter int ADDR_W      = 64,
   parameter int VALEN       = 48,
   parameter int PALEN       = 48,
   parameter int CANON_W     = 16,
   parameter int NUM_WIN     = 4,
   parameter int SEG64_W     = 4,
   parameter int SEG32_W     = 3,
   parameter int PSEG32_LSB  = 25,
   parameter int KERN_EN_BIT = 0,
   parameter int USER_EN_BIT = 3,
   parameter bit CLEAR_DATA  = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   input  logic [ADDR_W-1:0]              in_va,
   input  logic                           in_da,
   input  logic                           in_pg,
   input  logic [1:0]                     in_priv,
   input  logic                           in_mode32,
   input  logic [NUM_WIN-1:0][ADDR_W-1:0] in_win,
   output logic                           out_valid,
   output logic [1:0]                     out_code,
   output logic [ADDR_W-1:0]              out_pa,
   output logic [2:0]                     out_perm,
   output logic                           out_fwd_req,
   output logic [ADDR_W-1:0]              out_fwd_va
);

   localparam int IDX_W = $clog2(NUM_WIN);
   localparam logic [ADDR_W-1:0] PA_MASK =
      {{(ADDR_W-PALEN){1'b0}}, {PALEN{1'b1}}};

   // elaboration-time parameter checks
   if (NUM_WIN < 2) begin : g_err_nwin
      $error("dmw_xlate: NUM_WIN must be at least 2");
   end
   if (PALEN >= ADDR_W) begin : g_err_palen
      $error("dmw_xlate: PALEN must be below ADDR_W");
   end
   if (VALEN + CANON_W > ADDR_W) begin : g_err_canon
      $error("dmw_xlate: canonical field exceeds the address");
   end
   if (ADDR_W <= 32) begin : g_err_addr
      $error("dmw_xlate: ADDR_W must exceed 32");
   end
   if (PSEG32_LSB + SEG32_W > 32 - SEG32_W) begin : g_err_pseg
      $error("dmw_xlate: physical segment overlaps virtual segment");
   end
   if (KERN_EN_BIT == USER_EN_BIT) begin : g_err_priv
      $error("dmw_xlate: privilege enable bits must differ");
   end

   // effective address
   logic [ADDR_W-1:0] va_eff;

   always_comb begin
      va_eff = in_mode32 ? {{(ADDR_W-32){1'b0}}, in_va[31:0]} : in_va;
   end

   // window bank
   logic [NUM_WIN-1:0]  win_hit;
   logic [ADDR_W-1:0]   win_pa [NUM_WIN];

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      dmwx_win_match #(
         .ADDR_W      (ADDR_W),
         .VALEN       (VALEN),
         .SEG64_W     (SEG64_W),
         .SEG32_W     (SEG32_W),
         .PSEG32_LSB  (PSEG32_LSB),
         .KERN_EN_BIT (KERN_EN_BIT),
         .USER_EN_BIT (USER_EN_BIT)
      ) u_win (
         .win    (in_win[w]),
         .va     (va_eff),
         .mode32 (in_mode32),
         .priv   (in_priv),
         .hit    (win_hit[w]),
         .pa     (win_pa[w])
      );
   end

   logic             any_hit;
   logic [IDX_W-1:0] hit_idx;

   dmwx_first_hit #(
      .N     (NUM_WIN),
      .IDX_W (IDX_W)
   ) u_pick (
      .hits (win_hit),
      .any  (any_hit),
      .idx  (hit_idx)
   );

   logic canon_ok;

   dmwx_canon #(
      .ADDR_W  (ADDR_W),
      .VALEN   (VALEN),
      .CANON_W (CANON_W)
   ) u_canon (
      .va (va_eff),
      .ok (canon_ok)
   );

   // decision
   logic              direct;
   xl_code_e          nxt_code;
   logic [ADDR_W-1:0] nxt_pa;
   logic [2:0]        nxt_perm;
   logic              nxt_fwd;
   logic [ADDR_W-1:0] nxt_fwd_va;

   always_comb begin
      direct     = in_da && !in_pg;
      nxt_code   = XL_FORWARD;
      nxt_pa     = '0;
      nxt_perm   = PERM_NONE;
      nxt_fwd    = 1'b0;
      nxt_fwd_va = '0;
      if (direct) begin
         nxt_code = XL_MATCH;
         nxt_pa   = va_eff & PA_MASK;
         nxt_perm = PERM_ALL;
      end else if (any_hit) begin
         nxt_code = XL_MATCH;
         nxt_pa   = win_pa[hit_idx];
         nxt_perm = PERM_ALL;
      end else if (!canon_ok) begin
         nxt_code = XL_BADADDR;
      end else begin
         nxt_code   = XL_FORWARD;
         nxt_fwd    = 1'b1;
         nxt_fwd_va = va_eff;
      end
   end

   // output stage: control always reset, data optionally
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_fwd_req <= 1'b0;
      end else begin
         out_valid   <= in_valid;
         out_fwd_req <= in_valid && nxt_fwd;
      end
   end

   if (CLEAR_DATA) begin : g_data_rst
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_code   <= XL_MATCH;
            out_pa     <= '0;
            out_perm   <= PERM_NONE;
            out_fwd_va <= '0;
         end else if (in_valid) begin
            out_code   <= nxt_code;
            out_pa     <= nxt_pa;
            out_perm   <= nxt_perm;
            out_fwd_va <= nxt_fwd_va;
         end
      end
   end else begin : g_data_norst
      always_ff @(posedge clk) begin
         if (in_valid) begin
            out_code   <= nxt_code;
            out_pa     <= nxt_pa;
            out_perm   <= nxt_perm;
            out_fwd_va <= nxt_fwd_va;
         end
      end
   end

endmodule

// File: rtl/dmw_xlate_chk.sv
module dmw_xlate_chk #(
   parameter int ADDR_W = 64,
   parameter int PALEN  = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [ADDR_W-1:0] in_va,
   input logic              in_da,
   input logic              in_pg,
   input logic [1:0]        in_priv,
   input logic              in_mode32,
   input logic              out_valid,
   input logic [1:0]        out_code,
   input logic [ADDR_W-1:0] out_pa,
   input logic [2:0]        out_perm,
   input logic              out_fwd_req
);

   localparam logic [ADDR_W-1:0] PA_MASK =
      {{(ADDR_W-PALEN){1'b0}}, {PALEN{1'b1}}};

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R2

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !out_fwd_req); // R2

   AST_DIRECT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_da && !in_pg && !in_mode32 |=>
         out_code == 2'd0 && out_pa == ($past(in_va) & PA_MASK)); // R3

   AST_PRIV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !(in_da && !in_pg) && (in_priv == 2'd1 || in_priv == 2'd2)
         |=> out_code != 2'd0); // R4

   AST_MATCH_PERM: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_code == 2'd0 |-> out_perm == 3'b111); // R8

   AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_code != 2'd0 |-> out_perm == 3'b000 && out_pa == '0); // R11

   AST_FWD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_code == 2'd2 |-> out_fwd_req); // R10

   AST_BAD_NOFWD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_code == 2'd1 |-> !out_fwd_req); // R9

   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_code != 2'd3); // R10

endmodule

bind dmw_xlate dmw_xlate_chk #(
   .ADDR_W (ADDR_W),
   .PALEN  (PALEN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_va       (in_va),
   .in_da       (in_da),
   .in_pg       (in_pg),
   .in_priv     (in_priv),
   .in_mode32   (in_mode32),
   .out_valid   (out_valid),
   .out_code    (out_code),
   .out_pa      (out_pa),
   .out_perm    (out_perm),
   .out_fwd_req (out_fwd_req)
);

// File: tb/dmw_xlate_tb.sv
`timescale 1ns/1ps
module dmw_xlate_tb;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [63:0]      in_va = '0;
   logic             in_da = 1'b0;
   logic             in_pg = 1'b1;
   logic [1:0]       in_priv = 2'd0;
   logic             in_mode32 = 1'b0;
   logic [3:0][63:0] in_win = '0;
   logic             out_valid;
   logic [1:0]       out_code;
   logic [63:0]      out_pa;
   logic [2:0]       out_perm;
   logic             out_fwd_req;
   logic [63:0]      out_fwd_va;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dmw_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_va(in_va),
      .in_da(in_da), .in_pg(in_pg), .in_priv(in_priv), .in_mode32(in_mode32),
      .in_win(in_win), .out_valid(out_valid), .out_code(out_code),
      .out_pa(out_pa), .out_perm(out_perm), .out_fwd_req(out_fwd_req),
      .out_fwd_va(out_fwd_va)
   );

   localparam logic [1:0] C_MATCH = 2'd0, C_BAD = 2'd1, C_FWD = 2'd2;

   function automatic logic [63:0] win64(input logic [3:0] vseg,
                                         input logic k, input logic u);
      return {vseg, 60'd0} | {60'd0, u, 2'b00, k};
   endfunction

   function automatic logic [63:0] win32(input logic [2:0] vseg,
                                         input logic [2:0] pseg,
                                         input logic k, input logic u);
      return {32'd0, vseg, 1'b0, pseg, 21'd0, u, 2'b00, k};
   endfunction

   task automatic check(input string tag, input logic [1:0] ec,
                        input logic [63:0] epa, input logic [2:0] eperm,
                        input logic efwd, input logic [63:0] efva);
      checks++;
      if (out_valid !== 1'b1 || out_code !== ec || out_pa !== epa ||
          out_perm !== eperm || out_fwd_req !== efwd ||
          (efwd && out_fwd_va !== efva)) begin
         failures++;
         $display("FAIL %s: got v=%b code=%0d pa=%h perm=%b fwd=%b fva=%h exp v=1 code=%0d pa=%h perm=%b fwd=%b fva=%h",
                  tag, out_valid, out_code, out_pa, out_perm, out_fwd_req,
                  out_fwd_va, ec, epa, eperm, efwd, efva);
      end
   endtask

   // present one request; results are sampled at the following falling edge
   task automatic xact(input logic [63:0] va, input logic da, input logic pg,
                       input logic [1:0] priv, input logic m32);
      @(negedge clk);
      in_va = va; in_da = da; in_pg = pg; in_priv = priv; in_mode32 = m32;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      checks++;
      if (out_valid !== 1'b0 || out_fwd_req !== 1'b0) begin
         failures++;
         $display("FAIL R1: got valid=%b fwd=%b exp 0 0", out_valid, out_fwd_req);
      end
   endtask

   task automatic t_direct();
      in_win = '0;
      in_win[0] = win64(4'hF, 1'b1, 1'b1);
      xact(64'hFFFF_1234_5678_9ABC, 1'b1, 1'b0, 2'd0, 1'b0);
      check("R3 direct", C_MATCH, 64'h0000_1234_5678_9ABC, 3'b111, 1'b0, 64'd0);
      in_win = '0;
      xact(64'hFFFF_8000_0000_1000, 1'b1, 1'b1, 2'd0, 1'b0);
      check("R3 da+pg not direct R10", C_FWD, 64'd0, 3'b000, 1'b1, 64'hFFFF_8000_0000_1000);
   endtask

   task automatic t_latency();
      xact(64'h0000_0000_0000_4000, 1'b0, 1'b1, 2'd0, 1'b0);
      check("R2 result", C_FWD, 64'd0, 3'b000, 1'b1, 64'h0000_0000_0000_4000);
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_fwd_req !== 1'b0) begin
         failures++;
         $display("FAIL R2 idle: got valid=%b fwd=%b exp 0 0", out_valid, out_fwd_req);
      end
   endtask

   task automatic t_win64();
      in_win = '0;
      in_win[0] = win64(4'h9, 1'b1, 1'b0);
      in_win[2] = win64(4'hF, 1'b0, 1'b1);
      xact(64'h9000_0000_0ABC_D000, 1'b0, 1'b1, 2'd0, 1'b0);
      check("R5 R8 kernel hit noncanonical", C_MATCH, 64'h0000_0000_0ABC_D000, 3'b111, 1'b0, 64'd0);
      xact(64'h9000_0000_0ABC_D000, 1'b0, 1'b1, 2'd3, 1'b0);
      check("R4 user blocked R9", C_BAD, 64'd0, 3'b000, 1'b0, 64'd0);
      xact(64'hFFFF_8000_1234_5000, 1'b0, 1'b1, 2'd3, 1'b0);
      check("R4 user hit", C_MATCH, 64'h0000_8000_1234_5000, 3'b111, 1'b0, 64'd0);
      xact(64'hFFFF_8000_1234_5000, 1'b0, 1'b1, 2'd0, 1'b0);
      check("R4 kernel blocked R10", C_FWD, 64'd0, 3'b000, 1'b1, 64'hFFFF_8000_1234_5000);
      in_win[1] = win64(4'h9, 1'b1, 1'b1);
      xact(64'h9000_0000_0ABC_D000, 1'b0, 1'b1, 2'd1, 1'b0);
      check("R4 priv1 never hits R11", C_BAD, 64'd0, 3'b000, 1'b0, 64'd0);
      xact(64'h9000_0000_0ABC_D000, 1'b0, 1'b1, 2'd2, 1'b0);
      check("R4 priv2 never hits", C_BAD, 64'd0, 3'b000, 1'b0, 64'd0);
   endtask

   task automatic t_canon();
      in_win = '0;
      in_win[0] = win64(4'h8, 1'b1, 1'b1);
      xact(64'h9000_0000_0000_0000, 1'b0, 1'b1, 2'd0, 1'b0);
      check("R5 segment mismatch R9", C_BAD, 64'd0, 3'b000, 1'b0, 64'd0);
      xact(64'h0000_7FFF_FFFF_F000, 1'b0, 1'b1, 2'd0, 1'b0);
      check("R10 low canonical", C_FWD, 64'd0, 3'b000, 1'b1, 64'h0000_7FFF_FFFF_F000);
      xact(64'h0000_8000_0000_0000, 1'b0, 1'b1, 2'd0, 1'b0);
      check("R10 bit47 set zeros above", C_FWD, 64'd0, 3'b000, 1'b1, 64'h0000_8000_0000_0000);
      xact(64'h0001_0000_0000_0000, 1'b0, 1'b1, 2'd0, 1'b0);
      check("R9 bit48 set", C_BAD, 64'd0, 3'b000, 1'b0, 64'd0);
      xact(64'hFFFE_FFFF_FFFF_FFFF, 1'b0, 1'b1, 2'd0, 1'b0);
      check("R9 bit48 clear ones above", C_BAD, 64'd0, 3'b000, 1'b0, 64'd0);
   endtask

   task automatic t_win32();
      in_win = '0;
      in_win[0] = win32(3'd5, 3'd2, 1'b0, 1'b1);
      in_win[1] = win32(3'd5, 3'd6, 1'b1, 1'b0);
      in_win[3] = win32(3'd5, 3'd1, 1'b1, 1'b0);
      xact(64'h0000_0000_ABCD_1234, 1'b0, 1'b1, 2'd0, 1'b1);
      check("R7 first enabled window", C_MATCH, 64'h0000_0000_CBCD_1234, 3'b111, 1'b0, 64'd0);
      xact(64'h0000_0000_ABCD_1234, 1'b0, 1'b1, 2'd3, 1'b1);
      check("R7 R4 user picks window0", C_MATCH, 64'h0000_0000_4BCD_1234, 3'b111, 1'b0, 64'd0);
      in_win[1] = '0;
      xact(64'hDEAD_0000_ABCD_1234, 1'b0, 1'b1, 2'd0, 1'b1);
      check("R6 upper bits ignored", C_MATCH, 64'h0000_0000_2BCD_1234, 3'b111, 1'b0, 64'd0);
      xact(64'hDEAD_0000_1234_5678, 1'b0, 1'b1, 2'd0, 1'b1);
      check("R6 miss forwards zero-extended R10", C_FWD, 64'd0, 3'b000, 1'b1, 64'h0000_0000_1234_5678);
      xact(64'hDEAD_BEEF_8765_4321, 1'b1, 1'b0, 2'd0, 1'b1);
      check("R6 R3 direct in 32-bit", C_MATCH, 64'h0000_0000_8765_4321, 3'b111, 1'b0, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct();
      t_latency();
      t_win64();
      t_canon();
      t_win32();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule